// File: doc/BRIEF.md
# GPIO Port Group Register Controller

This block holds the software-visible state of one group of 32 general-purpose pins. A small word-addressed register bus with byte enables reads and writes it. Pin direction and output level each sit in one register. That register can be written directly, or changed atomically through clear, set and invert aliases, so software never needs a read-modify-write to change a few pins. Each pin also has a configuration byte that selects mux enable, input enable, pull enable and drive strength, and a 4-bit peripheral-function select. Two pins share one select byte.

A write-only bulk register loads the configuration byte and/or the function select of up to sixteen pins in one bus cycle. A 16-bit mask picks the pins, and one bit chooses the lower or upper half of the group. The input register shows the pad levels, gated per pin. An event port carries set, clear and invert masks that act on the output register with no bus access. The block drives per-pin output enable, output level, input enable, pull enable, drive strength, mux enable and mux select straight to the pad ring.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register is zero: all per-pin outputs are 0 and every readable word returns 0.
- R2: `bus_addr` is a word index with this map. 0 is direction, 1 clears direction, 2 sets direction and 3 inverts direction. 4 to 7 are the same four forms for the output register. 8 is the gated input (read-only). 9 is the per-pin sampling word. 10 is the bulk register. 11 is a 32-bit general control word (plain storage). 12 to 15 hold the function-select bytes and 16 to 23 hold the configuration bytes. Words 24 to 31 read as 0.
- R3: A write to word 0, 4, 9 or 11 replaces only the byte lanes whose `bus_be` bit is 1. Bit k of `bus_be` covers data bits 8k+7 down to 8k.
- R4: In a write to a clear, set or invert alias, each 1 bit in an enabled byte lane clears, sets or inverts that bit of its register. 0 bits and disabled lanes leave it unchanged. Reading any alias word returns its register.
- R5: `pin_oe` equals the direction register and `pin_out` equals the output register, both valid from the clock edge that stores a write.
- R6: The configuration byte of pin p sits in word 16 + p/4, lane p%4. Within the byte, bit 0 is mux enable, bit 1 input enable, bit 2 pull enable and bit 6 drive strength. Bits 3 to 5 and bit 7 are ignored on write and read as 0.
- R7: Byte n of the select area (word 12 + n/4, lane n%4) holds pin 2n's select in bits 3:0 and pin 2n+1's select in bits 7:4.
- R8: A write to word 10 acts on each pin j+16·h for which mask bit j (bits 15:0) is 1, where h is bit 31, whatever `bus_be` is. If bit 30 is 1, the pin's configuration is loaded: mux enable from bit 16, input enable from 17, pull from 18, drive from 22. If bit 28 is 1, the pin's select is loaded from bits 27:24. Word 10 reads as 0.
- R9: Reading word 8 returns `pad_in` bit i only where pin i's input enable or sampling bit is 1. Every other bit reads as 0.
- R10: With no bus write to the output words, each output bit whose `evt_clr` bit is 1 becomes 0. Otherwise it becomes 1 where `evt_set` is 1, and otherwise it is inverted where `evt_tgl` is 1.
- R11: When a bus write to the output words and an event hit the same output bit in one cycle, the bus write decides that bit. A plain write hits every bit of its enabled lanes; an alias write hits only its 1 bits in enabled lanes. Bits the bus does not hit still follow R10.
- R12: Writes to word 8 and to words 24 to 31 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe for the current word |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels |
| evt_set | input | 32 | Event mask: set output bits |
| evt_clr | input | 32 | Event mask: clear output bits |
| evt_tgl | input | 32 | Event mask: invert output bits |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output level |
| pin_ie | output | 32 | Per-pin input enable |
| pin_pull | output | 32 | Per-pin pull enable |
| pin_drv | output | 32 | Per-pin drive strength |
| pin_mux_en | output | 32 | Per-pin peripheral mux enable |
| pin_mux_sel | output | 128 | Per-pin 4-bit function select, pin p at bits 4p+3:4p |

## Verification
In a single cycle the output register can get both a bus update and an event mask. Which of the two wins is decided bit by bit. The bench provokes this with directed cycles. In one, an output-set write overlaps a clear event, half of whose bits the write does not touch. In another, a byte-limited plain write meets a set event just outside its enabled lane. Each result is checked against a literal value. A long phase of random bus traffic with random event masks is then compared every cycle against a behavioural model. The model settles each bit from the bus hit first and the event precedence second.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

   localparam int unsigned REG_ADDR_W = 5;
   typedef logic [REG_ADDR_W-1:0] word_idx_t;

   // alias form is taken from the two low word-index bits
   typedef enum logic [1:0] {
      AK_PLAIN = 2'd0,
      AK_CLR   = 2'd1,
      AK_SET   = 2'd2,
      AK_TGL   = 2'd3
   } alias_kind_e;

   localparam word_idx_t WI_IN   = 5'd8;
   localparam word_idx_t WI_SAMP = 5'd9;
   localparam word_idx_t WI_BULK = 5'd10;
   localparam word_idx_t WI_GEN  = 5'd11;

   // configuration byte bit positions
   localparam int unsigned CB_MUXEN = 0;
   localparam int unsigned CB_INEN  = 1;
   localparam int unsigned CB_PULL  = 2;
   localparam int unsigned CB_DRV   = 6;

   // bulk word bit positions
   localparam int unsigned BK_MUXEN  = 16;
   localparam int unsigned BK_INEN   = 17;
   localparam int unsigned BK_PULL   = 18;
   localparam int unsigned BK_DRV    = 22;
   localparam int unsigned BK_SEL_LO = 24;
   localparam int unsigned BK_WRSEL  = 28;
   localparam int unsigned BK_WRCFG  = 30;
   localparam int unsigned BK_HALF   = 31;

   typedef struct packed {
      logic drv;
      logic pull;
      logic inen;
      logic muxen;
   } pin_cfg_t;

endpackage

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  alias_kind_e      wr_kind,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] lane_mask,
   input  logic [WIDTH-1:0] evt_set,
   input  logic [WIDTH-1:0] evt_clr,
   input  logic [WIDTH-1:0] evt_tgl,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] bus_hit;
   logic [WIDTH-1:0] bus_val;
   logic [WIDTH-1:0] evt_free;
   logic [WIDTH-1:0] evt_val;
   logic [WIDTH-1:0] q_nxt;

   always_comb begin
      bus_hit = '0;
      bus_val = q;
      if (wr_en) begin
         unique case (wr_kind)
            AK_PLAIN: begin bus_hit = lane_mask;         bus_val = wdata; end
            AK_CLR:   begin bus_hit = wdata & lane_mask; bus_val = '0;    end
            AK_SET:   begin bus_hit = wdata & lane_mask; bus_val = '1;    end
            AK_TGL:   begin bus_hit = wdata & lane_mask; bus_val = ~q;    end
         endcase
      end
   end

   // clear beats set, set beats invert
   assign evt_free = ~(evt_set | evt_clr);
   assign evt_val  = ((q & evt_free) ^ (evt_tgl & evt_free)) | (evt_set & ~evt_clr);

   // the bus decides every bit it hits
   assign q_nxt = (bus_hit & bus_val) | (~bus_hit & evt_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

endmodule

// File: rtl/gpio_pin_cfg.sv
`timescale 1ns/1ps
module gpio_pin_cfg
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PIN_CNT = 32,
   parameter int unsigned MUX_W   = 4,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned CSEL_W = $clog2(PIN_CNT / LANES),
   localparam int unsigned MSEL_W = $clog2((PIN_CNT * MUX_W) / DATA_W),
   localparam int unsigned HALF   = PIN_CNT / 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_cfg,
   input  logic [CSEL_W-1:0]        cfg_sel,
   input  logic                     wr_sel,
   input  logic [MSEL_W-1:0]        sel_sel,
   input  logic                     wr_bulk,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [LANES-1:0]         be,
   output pin_cfg_t [PIN_CNT-1:0]   cfg_q,
   output logic [PIN_CNT*MUX_W-1:0] sel_q
);

   // reserved bits of the configuration bytes and the bulk word
   logic unused_rsvd;
   assign unused_rsvd = ^{wdata[21:19], wdata[23], wdata[29]};

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      localparam int unsigned CW = p / LANES;
      localparam int unsigned CL = p % LANES;
      localparam int unsigned MW = p / (2 * LANES);
      localparam int unsigned ML = (p / 2) % LANES;
      localparam int unsigned MN = p % 2;
      localparam int unsigned BH = p / HALF;
      localparam int unsigned BB = p % HALF;

      pin_cfg_t          cfg_r;
      logic [MUX_W-1:0]  sel_r;
      logic              bus_cfg_hit;
      logic              bus_sel_hit;
      logic              bulk_hit;

      assign bus_cfg_hit = wr_cfg && (cfg_sel == CSEL_W'(CW)) && be[CL];
      assign bus_sel_hit = wr_sel && (sel_sel == MSEL_W'(MW)) && be[ML];
      assign bulk_hit    = wr_bulk && (wdata[BK_HALF] == 1'(BH)) && wdata[BB];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_r <= '0;
         end else if (bus_cfg_hit) begin
            cfg_r.drv   <= wdata[CL*8 + CB_DRV];
            cfg_r.pull  <= wdata[CL*8 + CB_PULL];
            cfg_r.inen  <= wdata[CL*8 + CB_INEN];
            cfg_r.muxen <= wdata[CL*8 + CB_MUXEN];
         end else if (bulk_hit && wdata[BK_WRCFG]) begin
            cfg_r.drv   <= wdata[BK_DRV];
            cfg_r.pull  <= wdata[BK_PULL];
            cfg_r.inen  <= wdata[BK_INEN];
            cfg_r.muxen <= wdata[BK_MUXEN];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_r <= '0;
         else if (bus_sel_hit)
            sel_r <= wdata[ML*8 + MN*MUX_W +: MUX_W];
         else if (bulk_hit && wdata[BK_WRSEL])
            sel_r <= wdata[BK_SEL_LO +: MUX_W];
      end

      assign cfg_q[p]                = cfg_r;
      assign sel_q[p*MUX_W +: MUX_W] = sel_r;
   end

endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
module gpio_read_mux
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PIN_CNT = 32,
   parameter int unsigned MUX_W   = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  word_idx_t                addr,
   input  logic [DATA_W-1:0]        dir_q,
   input  logic [DATA_W-1:0]        out_q,
   input  logic [PIN_CNT-1:0]       pad_in,
   input  logic [DATA_W-1:0]        samp_q,
   input  logic [DATA_W-1:0]        gen_q,
   input  pin_cfg_t [PIN_CNT-1:0]   cfg_q,
   input  logic [PIN_CNT*MUX_W-1:0] sel_q,
   output logic [DATA_W-1:0]        rdata
);

   logic [PIN_CNT*8-1:0] cfg_flat;
   logic [PIN_CNT-1:0]   in_open;

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_rd
      assign cfg_flat[p*8 +: 8] = {1'b0, cfg_q[p].drv, 3'b000,
                                   cfg_q[p].pull, cfg_q[p].inen, cfg_q[p].muxen};
      assign in_open[p]         = cfg_q[p].inen | samp_q[p];
   end

   always_comb begin
      rdata = '0;
      if (addr[4:2] == 3'b000)
         rdata = dir_q;
      else if (addr[4:2] == 3'b001)
         rdata = out_q;
      else if (addr == WI_IN)
         rdata = pad_in & in_open;
      else if (addr == WI_SAMP)
         rdata = samp_q;
      else if (addr == WI_GEN)
         rdata = gen_q;
      else if (addr[4:2] == 3'b011)
         rdata = sel_q[{addr[1:0], 5'b00000} +: DATA_W];
      else if (addr[4:3] == 2'b10)
         rdata = cfg_flat[{addr[2:0], 5'b00000} +: DATA_W];
   end

endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PIN_CNT = 32,
   parameter int unsigned MUX_W   = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic [DATA_W/8-1:0]      bus_be,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [PIN_CNT-1:0]       pad_in,
   input  logic [PIN_CNT-1:0]       evt_set,
   input  logic [PIN_CNT-1:0]       evt_clr,
   input  logic [PIN_CNT-1:0]       evt_tgl,
   output logic [PIN_CNT-1:0]       pin_oe,
   output logic [PIN_CNT-1:0]       pin_out,
   output logic [PIN_CNT-1:0]       pin_ie,
   output logic [PIN_CNT-1:0]       pin_pull,
   output logic [PIN_CNT-1:0]       pin_drv,
   output logic [PIN_CNT-1:0]       pin_mux_en,
   output logic [PIN_CNT*MUX_W-1:0] pin_mux_sel
);

   localparam int unsigned LANES = DATA_W / 8;

   // the word map is fixed; reject any other shape at elaboration
   if (PIN_CNT != 32 || DATA_W != 32 || MUX_W != 4 || ADDR_W != REG_ADDR_W) begin : g_bad_shape
      $error("gpio_bank_regs: word map needs 32 pins, 32-bit data, 4-bit selects, 5-bit word index");
   end

   logic [DATA_W-1:0] lane_mask;
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      assign lane_mask[b] = bus_be[b / 8];
   end

   logic [DATA_W-1:0] dir_q, out_q, sample_mode, gen_q;
   pin_cfg_t [PIN_CNT-1:0] cfg_q;
   logic wr_dir, wr_out, wr_samp, wr_gen, wr_bulk, wr_cfg, wr_sel;
   alias_kind_e wr_kind;

   assign wr_kind = alias_kind_e'(bus_addr[1:0]);
   assign wr_dir  = bus_we && (bus_addr[4:2] == 3'b000);
   assign wr_out  = bus_we && (bus_addr[4:2] == 3'b001);
   assign wr_samp = bus_we && (bus_addr == WI_SAMP);
   assign wr_gen  = bus_we && (bus_addr == WI_GEN);
   assign wr_bulk = bus_we && (bus_addr == WI_BULK);
   assign wr_sel  = bus_we && (bus_addr[4:2] == 3'b011);
   assign wr_cfg  = bus_we && (bus_addr[4:3] == 2'b10);

   gpio_alias_reg #(.WIDTH(DATA_W)) i_dir (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_dir), .wr_kind(wr_kind),
      .wdata(bus_wdata), .lane_mask(lane_mask),
      .evt_set('0), .evt_clr('0), .evt_tgl('0), .q(dir_q));

   gpio_alias_reg #(.WIDTH(DATA_W)) i_out (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_out), .wr_kind(wr_kind),
      .wdata(bus_wdata), .lane_mask(lane_mask),
      .evt_set(evt_set), .evt_clr(evt_clr), .evt_tgl(evt_tgl), .q(out_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_mode <= '0;
         gen_q       <= '0;
      end else begin
         if (wr_samp) sample_mode <= (sample_mode & ~lane_mask) | (bus_wdata & lane_mask);
         if (wr_gen)  gen_q       <= (gen_q & ~lane_mask) | (bus_wdata & lane_mask);
      end
   end

   gpio_pin_cfg #(.PIN_CNT(PIN_CNT), .MUX_W(MUX_W), .DATA_W(DATA_W)) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_cfg(wr_cfg), .cfg_sel(bus_addr[2:0]),
      .wr_sel(wr_sel), .sel_sel(bus_addr[1:0]),
      .wr_bulk(wr_bulk), .wdata(bus_wdata), .be(bus_be[LANES-1:0]),
      .cfg_q(cfg_q), .sel_q(pin_mux_sel));

   gpio_read_mux #(.PIN_CNT(PIN_CNT), .MUX_W(MUX_W), .DATA_W(DATA_W)) i_rd (
      .addr(bus_addr), .dir_q(dir_q), .out_q(out_q), .pad_in(pad_in),
      .samp_q(sample_mode), .gen_q(gen_q), .cfg_q(cfg_q), .sel_q(pin_mux_sel),
      .rdata(bus_rdata));

   assign pin_oe  = dir_q;
   assign pin_out = out_q;
   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pinout
      assign pin_ie[p]     = cfg_q[p].inen;
      assign pin_pull[p]   = cfg_q[p].pull;
      assign pin_drv[p]    = cfg_q[p].drv;
      assign pin_mux_en[p] = cfg_q[p].muxen;
   end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
`timescale 1ns/1ps
module gpio_bank_regs_chk #(
   parameter int unsigned PIN_CNT = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [PIN_CNT-1:0]  evt_clr,
   input logic [PIN_CNT-1:0]  pin_oe,
   input logic [PIN_CNT-1:0]  pin_out,
   input logic [PIN_CNT-1:0]  pin_ie,
   input logic [DATA_W-1:0]   sample_mode
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0 && pin_ie == '0));

   assert_set_alias_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 5'd2 && bus_be == '1 && bus_wdata == '1) |=> (pin_oe == '1));

   assert_event_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_we && bus_addr[4:2] == 3'b001) && evt_clr != '0)
      |=> ((pin_out & $past(evt_clr)) == '0));

   assert_bus_over_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 5'd6 && bus_be == '1)
      |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

   assert_input_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 5'd8) |-> ((bus_rdata & ~(pin_ie | sample_mode)) == '0));

   assert_bulk_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 5'd10) |-> (bus_rdata == '0));

   assert_cfg_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[4:3] == 2'b10) |-> ((bus_rdata & 32'hB8B8_B8B8) == '0));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .PIN_CNT(PIN_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [4:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [3:0]   bus_be = '0;
   logic [31:0]  bus_rdata;
   logic [31:0]  pad_in = '0;
   logic [31:0]  evt_set = '0, evt_clr = '0, evt_tgl = '0;
   logic [31:0]  pin_oe, pin_out, pin_ie, pin_pull, pin_drv, pin_mux_en;
   logic [127:0] pin_mux_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_bank_regs i_gpio_bank_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .evt_set(evt_set), .evt_clr(evt_clr), .evt_tgl(evt_tgl),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_ie(pin_ie), .pin_pull(pin_pull),
      .pin_drv(pin_drv), .pin_mux_en(pin_mux_en), .pin_mux_sel(pin_mux_sel));

   // behavioural reference state
   logic [31:0] m_dir, m_out, m_samp, m_gen;
   logic [7:0]  m_cfg [32];
   logic [3:0]  m_sel [32];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] r;
      r = '0;
      if (a < 4) r = m_dir;
      else if (a < 8) r = m_out;
      else if (a == 8) begin
         for (int i = 0; i < 32; i++) r[i] = pad_in[i] & (m_cfg[i][1] | m_samp[i]);
      end
      else if (a == 9) r = m_samp;
      else if (a == 11) r = m_gen;
      else if (a >= 12 && a < 16) begin
         for (int b = 0; b < 4; b++) begin
            int n;
            n = (a - 12) * 4 + b;
            r[b*8 +: 8] = {m_sel[2*n+1], m_sel[2*n]};
         end
      end
      else if (a >= 16 && a < 24) begin
         for (int b = 0; b < 4; b++) r[b*8 +: 8] = m_cfg[(a - 16) * 4 + b];
      end
      return r;
   endfunction

   task automatic model_update();
      int a;
      a = int'(bus_addr);
      if (!rst_n) begin
         m_dir = '0; m_out = '0; m_samp = '0; m_gen = '0;
         for (int i = 0; i < 32; i++) begin m_cfg[i] = '0; m_sel[i] = '0; end
         return;
      end
      for (int i = 0; i < 32; i++) begin
         bit lane_on, hit, val, cur;
         lane_on = bus_be[i / 8];
         hit = 0; val = 0;
         cur = (a < 4) ? m_dir[i] : m_out[i];
         if (bus_we && a < 8) begin
            case (a % 4)
               0: if (lane_on) begin hit = 1; val = bus_wdata[i]; end
               1: if (lane_on && bus_wdata[i]) begin hit = 1; val = 0; end
               2: if (lane_on && bus_wdata[i]) begin hit = 1; val = 1; end
               default: if (lane_on && bus_wdata[i]) begin hit = 1; val = !cur; end
            endcase
         end
         if (hit && a < 4) m_dir[i] = val;
         if (hit && a >= 4) m_out[i] = val;
         else begin
            if (evt_clr[i]) m_out[i] = 0;
            else if (evt_set[i]) m_out[i] = 1;
            else if (evt_tgl[i]) m_out[i] = !m_out[i];
         end
      end
      if (bus_we) begin
         for (int b = 0; b < 4; b++) begin
            if (bus_be[b]) begin
               if (a == 9)  m_samp[b*8 +: 8] = bus_wdata[b*8 +: 8];
               if (a == 11) m_gen[b*8 +: 8]  = bus_wdata[b*8 +: 8];
               if (a >= 12 && a < 16) begin
                  int n;
                  n = (a - 12) * 4 + b;
                  m_sel[2*n]   = bus_wdata[b*8 +: 4];
                  m_sel[2*n+1] = bus_wdata[b*8+4 +: 4];
               end
               if (a >= 16 && a < 24) m_cfg[(a - 16) * 4 + b] = bus_wdata[b*8 +: 8] & 8'h47;
            end
         end
         if (a == 10) begin
            for (int j = 0; j < 16; j++) begin
               if (bus_wdata[j]) begin
                  int pin;
                  pin = j + (bus_wdata[31] ? 16 : 0);
                  if (bus_wdata[30]) m_cfg[pin] = {1'b0, bus_wdata[22], 3'b000, bus_wdata[18:16]};
                  if (bus_wdata[28]) m_sel[pin] = bus_wdata[27:24];
               end
            end
         end
      end
   endtask

   task automatic compare_all();
      logic [31:0] e_ie, e_pull, e_drv, e_men;
      for (int i = 0; i < 32; i++) begin
         e_men[i] = m_cfg[i][0]; e_ie[i] = m_cfg[i][1];
         e_pull[i] = m_cfg[i][2]; e_drv[i] = m_cfg[i][6];
      end
      chk("R5 pin_oe", pin_oe, m_dir);
      chk("R5 pin_out", pin_out, m_out);
      chk("R6 pin_ie", pin_ie, e_ie);
      chk("R6 pin_pull", pin_pull, e_pull);
      chk("R6 pin_drv", pin_drv, e_drv);
      chk("R6 pin_mux_en", pin_mux_en, e_men);
      for (int w = 0; w < 4; w++) begin
         logic [31:0] e;
         for (int k = 0; k < 8; k++) e[k*4 +: 4] = m_sel[w*8 + k];
         chk("R7 pin_mux_sel", pin_mux_sel[w*32 +: 32], e);
      end
      chk("R2 bus_rdata", bus_rdata, m_read(int'(bus_addr)));
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      #1;
      compare_all();
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
      step();
      bus_we = 0; evt_set = '0; evt_clr = '0; evt_tgl = '0;
   endtask

   task automatic rd(input logic [4:0] a);
      bus_we = 0; bus_addr = a;
      step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step();
      #1 rst_n = 1;
      // R1: reset state
      chk("R1 oe", pin_oe, 32'h0);
      chk("R1 out", pin_out, 32'h0);
      chk("R1 mux_sel", pin_mux_sel[31:0], 32'h0);
      rd(5'd16);
      chk("R1 cfg read", bus_rdata, 32'h0);

      // R3: byte-lane plain write
      wr(5'd0, 32'hA5A5_00FF, 4'b0101);
      chk("R3 dir lanes", pin_oe, 32'h00A5_00FF);
      // R4: aliases
      wr(5'd2, 32'hFF00_0000, 4'hF);
      chk("R4 set", pin_oe, 32'hFFA5_00FF);
      wr(5'd1, 32'h0000_00F0, 4'hF);
      chk("R4 clr", pin_oe, 32'hFFA5_000F);
      wr(5'd3, 32'h0F0F_0F0F, 4'b0001);
      chk("R4 tgl lane", pin_oe, 32'hFFA5_0000);
      rd(5'd3);
      chk("R4 alias read", bus_rdata, 32'hFFA5_0000);

      // R5 / R10: output and events
      wr(5'd4, 32'h1234_5678, 4'hF);
      chk("R5 out", pin_out, 32'h1234_5678);
      evt_set = 32'h0000_FF00; evt_clr = 32'h0000_0F00; evt_tgl = 32'hF000_0000;
      step();
      evt_set = '0; evt_clr = '0; evt_tgl = '0;
      chk("R10 precedence", pin_out, 32'hE234_F078);

      // R11: bus and event in one cycle
      evt_clr = 32'h0000_000F;
      wr(5'd6, 32'h0000_0003, 4'hF);
      chk("R11 set vs clr", pin_out, 32'hE234_F073);
      evt_set = 32'h0000_0100;
      wr(5'd4, 32'h0000_0000, 4'b0001);
      chk("R11 lane vs set", pin_out, 32'hE234_F100);

      // R6: configuration byte
      wr(5'd17, 32'hFFFF_FFFF, 4'b1000);
      chk("R6 ie pin7", pin_ie, 32'h0000_0080);
      chk("R6 drv pin7", pin_drv, 32'h0000_0080);
      rd(5'd17);
      chk("R6 reserved", bus_rdata, 32'h4700_0000);

      // R7: select byte
      wr(5'd13, 32'h0000_00BA, 4'b0001);
      chk("R7 pin8", {28'h0, pin_mux_sel[8*4 +: 4]}, 32'hA);
      chk("R7 pin9", {28'h0, pin_mux_sel[9*4 +: 4]}, 32'hB);

      // R8: bulk writes
      wr(5'd10, 32'hD542_0003, 4'b0000);
      chk("R8 bulk ie", pin_ie, 32'h0003_0080);
      chk("R8 bulk drv", pin_drv, 32'h0003_0080);
      chk("R8 bulk sel", {28'h0, pin_mux_sel[16*4 +: 4]}, 32'h5);
      rd(5'd10);
      chk("R8 read zero", bus_rdata, 32'h0);
      wr(5'd10, 32'h1C00_0100, 4'hF);
      rd(5'd13);
      chk("R8 sel only", bus_rdata, 32'h0000_00BC);
      chk("R8 cfg kept", pin_mux_en, 32'h0000_0080);

      // R9: input gating
      pad_in = 32'hFFFF_FFFF;
      rd(5'd8);
      chk("R9 ie gate", bus_rdata, 32'h0003_0080);
      wr(5'd9, 32'h0000_FF00, 4'hF);
      rd(5'd8);
      chk("R9 sample gate", bus_rdata, 32'h0003_FF80);

      // R12: writes with no effect
      wr(5'd24, 32'hFFFF_FFFF, 4'hF);
      rd(5'd24);
      chk("R12 unmapped", bus_rdata, 32'h0);
      wr(5'd8, 32'h0000_0000, 4'hF);
      rd(5'd8);
      chk("R12 input word", bus_rdata, 32'h0003_FF80);

      // R2: general word with lanes
      wr(5'd11, 32'hCAFE_BABE, 4'b0011);
      rd(5'd11);
      chk("R2 general word", bus_rdata, 32'h0000_BABE);

      // random traffic against the model, compared every clock
      for (int c = 0; c < 3000; c++) begin
         bus_we    = $urandom_range(0, 1) == 1;
         bus_addr  = 5'($urandom_range(0, 31));
         bus_wdata = $urandom();
         bus_be    = 4'($urandom_range(0, 15));
         pad_in    = $urandom();
         evt_set   = $urandom() & $urandom();
         evt_clr   = $urandom() & $urandom();
         evt_tgl   = $urandom() & $urandom();
         step();
      end
      bus_we = 0; evt_set = '0; evt_clr = '0; evt_tgl = '0;
      step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule